// File: doc/BRIEF.md
# Segment Relocation and Protection Unit

This unit maps 16-bit logical addresses to 16-bit physical addresses through a small per-process segment table. The top four bits of a logical address pick one of sixteen segments. The low twelve bits form an offset into that segment. Each table entry holds a 16-bit base, a 12-bit limit and a present flag. The physical address is the base added to the offset. The offset is also compared against the limit, so the same lookup relocates the access and protects memory.

Supervisor software loads the table through a write port before it hands the processor to a process. Each request gives either a physical address or exactly one fault flag. A fault means the segment is not resident or the offset lies beyond the segment's bound. Fetching absent segments and handling faults are left to software.

Top module: `segXlate`

## Requirements
- R1: After reset, rspValid is 0, rspPhysAddr and both fault flags are 0, and every table entry is not present, so a request to any segment returns rspFaultAbsent.
- R2: The segment index is reqAddr[15:12] and the offset is reqAddr[11:0].
- R3: For a legal access, rspPhysAddr equals the base plus the zero-extended offset, taken modulo 2^16. For example, base 0x2020 with logical address 0x12F0 gives 0x2310, and base 0xF800 with offset 0x900 gives 0x0100.
- R4: An access to a present segment with offset > limit sets rspFaultLimit. An offset equal to the limit is legal.
- R5: An access to a segment whose present flag is 0 sets rspFaultAbsent and never rspFaultLimit, whatever its offset and limit.
- R6: When either fault flag is set, rspPhysAddr is 0.
- R7: rspValid is 1 in the cycle after each cycle in which reqValid is 1, and 0 otherwise. The result it carries belongs to that request.
- R8: With wrEn at 1 on a clock edge, entry wrIdx takes wrBase, wrLimit and wrPresent. Requests in later cycles use the new contents.
- R9: A request in the same cycle as a table write to the entry it reads is translated with the entry's contents from before the write.
- R10: While rspValid is 0, rspPhysAddr, rspFaultAbsent and rspFaultLimit are all 0.
- R11: Writing an entry with wrPresent at 0 makes later requests to that segment fault as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A translation request is present this cycle |
| reqAddr | input | 16 | Logical address: segment index in bits 15:12, offset in bits 11:0 |
| wrEn | input | 1 | Load one table entry at this edge |
| wrIdx | input | 4 | Index of the entry to load |
| wrBase | input | 16 | Base address to load |
| wrLimit | input | 12 | Highest legal offset to load |
| wrPresent | input | 1 | Present flag to load |
| rspValid | output | 1 | Result of the previous cycle's request |
| rspPhysAddr | output | 16 | Translated address, or 0 when the access faults |
| rspFaultAbsent | output | 1 | The segment is not present |
| rspFaultLimit | output | 1 | The offset exceeds the segment limit |

## Verification
Every result is due exactly one clock after its request, since one register stage sits between the request inputs and the response outputs. A table write becomes visible to requests one edge after it is presented. The bench drives inputs on the falling edge and keeps a reference table. It computes each expectation from that table before applying the same cycle's write, which gives the old-contents rule for a write and a lookup in the same cycle. On the next falling edge it compares all four response outputs with that expectation. Directed steps cover the reset state, the worked relocation, wrap-around, the limit boundary, fault priority and same-cycle writes. A long pseudo-random run follows, still checked every cycle.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  localparam int ADDR_W = 16;
  localparam int SEG_W  = 4;
  localparam int OFF_W  = ADDR_W - SEG_W;
  localparam int NUM_SEG = 1 << SEG_W;

  typedef struct packed {
    logic              present;
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  limit;
  } segEntry_t;

  typedef struct packed {
    logic captureEn;
    logic tableWrEn;
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segxl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        wrEn,
  output segStrobes_t strobes,
  output logic        rspValid
);
  always_comb begin
    strobes.captureEn = reqValid;
    strobes.tableWrEn = wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segxl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEG_W,
  localparam int OW = AW - SW,
  localparam int NS = 1 << SW
)(
  input  logic          clk,
  input  logic          rstN,
  input  segStrobes_t   strobes,
  input  logic [AW-1:0] reqAddr,
  input  logic [SW-1:0] wrIdx,
  input  logic [AW-1:0] wrBase,
  input  logic [OW-1:0] wrLimit,
  input  logic          wrPresent,
  output logic [AW-1:0] physQ,
  output logic          faultAbsentQ,
  output logic          faultLimitQ
);
  segEntry_t tableQ [NS];
  logic [NS-1:0] wrHit;

  for (genvar g = 0; g < NS; g++) begin : gDecode
    assign wrHit[g] = strobes.tableWrEn && (wrIdx == SW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (!rstN)          tableQ[i] <= '0;
      else if (wrHit[i]) begin
        tableQ[i].present <= wrPresent;
        tableQ[i].base    <= wrBase;
        tableQ[i].limit   <= wrLimit;
      end
    end
  end

  logic [SW-1:0] segIdx;
  logic [OW-1:0] offset;
  segEntry_t     entry;
  logic [AW-1:0] sum;
  logic          absentNow, overNow;

  always_comb begin
    segIdx    = reqAddr[AW-1 -: SW];
    offset    = reqAddr[OW-1:0];
    entry     = tableQ[segIdx];
    sum       = entry.base + {{SW{1'b0}}, offset};
    absentNow = !entry.present;
    overNow   = entry.present && (offset > entry.limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.captureEn) begin
      physQ        <= '0;
      faultAbsentQ <= 1'b0;
      faultLimitQ  <= 1'b0;
    end else begin
      physQ        <= (absentNow || overNow) ? '0 : sum;
      faultAbsentQ <= absentNow;
      faultLimitQ  <= overNow;
    end
  end

  assert_table_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tableWrEn |=> (tableQ[$past(wrIdx)].present == $past(wrPresent)));
  assert_absent_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultAbsentQ |-> !faultLimitQ);
  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultAbsentQ || faultLimitQ) |-> (physQ == '0));
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segxl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrEn,
  input  logic [SEG_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [OFF_W-1:0]  wrLimit,
  input  logic              wrPresent,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFaultAbsent,
  output logic              rspFaultLimit
);
  segStrobes_t strobes;

  segCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrEn(wrEn),
    .strobes(strobes), .rspValid(rspValid)
  );

  segDatapath #(.AW(ADDR_W), .SW(SEG_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .wrIdx(wrIdx), .wrBase(wrBase), .wrLimit(wrLimit), .wrPresent(wrPresent),
    .physQ(rspPhysAddr), .faultAbsentQ(rspFaultAbsent), .faultLimitQ(rspFaultLimit)
  );

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspPhysAddr == '0 && !rspFaultAbsent && !rspFaultLimit));
endmodule

// File: tb/tb_segXlate.sv
module tb_segXlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [15:0] wrBase = '0;
  logic [11:0] wrLimit = '0;
  logic        wrPresent = 1'b0;
  logic        rspValid;
  logic [15:0] rspPhysAddr;
  logic        rspFaultAbsent, rspFaultLimit;

  always #5 clk = ~clk;

  segXlate dut (.*);

  int tests = 0, fails = 0;
  int mBase [16];
  int mLim  [16];
  bit mPres [16];
  int expV = 0, expPhys = 0, expAbs = 0, expLim = 0;
  string expTag = "R1";

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input int addr, input bit we, input int idx,
                      input int b, input int l, input bit p, input string tag);
    int seg, off;
    @(negedge clk);
    check(expTag, "valid R7", int'(rspValid), expV);
    check(expTag, "phys", int'(rspPhysAddr), expPhys);
    check(expTag, "absent", int'(rspFaultAbsent), expAbs);
    check(expTag, "limit", int'(rspFaultLimit), expLim);
    reqValid = rv; reqAddr = addr[15:0];
    wrEn = we; wrIdx = idx[3:0]; wrBase = b[15:0]; wrLimit = l[11:0]; wrPresent = p;
    seg = (addr >> 12) & 15;  // R2 field split
    off = addr & 12'hFFF;
    expV = rv; expPhys = 0; expAbs = 0; expLim = 0;
    if (rv) begin
      if (!mPres[seg]) expAbs = 1;
      else if (off > mLim[seg]) expLim = 1;
      else expPhys = (mBase[seg] + off) & 16'hFFFF;
    end
    if (we) begin
      mBase[idx & 15] = b & 16'hFFFF;
      mLim[idx & 15] = l & 12'hFFF;
      mPres[idx & 15] = p;
    end
    expTag = tag;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mBase[i] = 0; mLim[i] = 0; mPres[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step(1, 16'h12F0, 0, 0, 0, 0, 0, "R1");           // absent after reset
    step(0, 0, 1, 1, 16'h2020, 12'hFFF, 1, "R10");
    step(1, 16'h12F0, 0, 0, 0, 0, 0, "R3");           // 0x2310
    step(0, 0, 1, 3, 16'h8000, 12'h100, 1, "R10");
    step(1, 16'h3100, 0, 0, 0, 0, 0, "R4");           // boundary legal
    step(1, 16'h3101, 0, 0, 0, 0, 0, "R4");           // one past limit
    step(0, 0, 1, 5, 16'h1000, 12'h000, 0, "R10");
    step(1, 16'h5FFF, 0, 0, 0, 0, 0, "R5");           // absent wins over limit
    step(0, 0, 1, 2, 16'hF800, 12'hFFF, 1, "R10");
    step(1, 16'h2900, 0, 0, 0, 0, 0, "R3");           // wrap to 0x0100
    step(1, 16'hA123, 0, 0, 0, 0, 0, "R2");           // segment 10 still absent
    step(1, 16'h1010, 1, 1, 16'h4000, 12'hFFF, 1, "R9"); // old base 0x2020
    step(1, 16'h1010, 0, 0, 0, 0, 0, "R8");           // new base 0x4000
    step(0, 0, 1, 1, 16'h4000, 12'hFFF, 0, "R10");
    step(1, 16'h1010, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 16'h2FFF, 0, 0, 0, 0, 0, "R6");           // legal, then faults below
    step(1, 16'h3FFF, 0, 0, 0, 0, 0, "R6");
    for (int n = 0; n < 2000; n++) begin
      step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 16'hFFFF)),
           bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 16'hFFFF)), int'($urandom_range(0, 12'hFFF)),
           bit'($urandom_range(0, 4) != 0), "R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule